// File: doc/BRIEF.md
# UART with programmable oversampling

This block is a serial port for 8-bit frames with one start bit and one stop bit. Software sees it as a 16550-style register file on a 32-bit bus, where each register takes one word address. The transmitter takes a byte from a one-entry holding register and sends it LSB first. The receiver watches the RX line for a falling edge, times the frame from that edge, and places the byte in a receive register together with a data-ready flag.

The length of one bit is set by a 16-bit divisor and a rate mode. Two modes have fixed factors: sixteen ticks per bit or four ticks per bit. A third mode takes the number of ticks per bit from a count register. The receiver samples RX once per bit, at a tick index. In the fixed modes that index is fixed near mid-bit. In the programmable mode it comes from a sample-point register.

Status flags report received data, framing errors and the transmitter state. Two self-clearing control bits flush the receive side and the transmit side. Two modem control bits drive the DTR and RTS pins.

Top module: `uart_os`

## Requirements
- R1: The register word offsets are fixed by the decode. They are: 0 data, 1 interrupt enable, 2 FIFO control on write and identification on read, 3 line control, 4 modem control, 5 line status, 6 modem status (reads 0), 7 scratch, 8 unused (reads 0), 9 rate mode, 10 tick count, 11 sample point. Interrupt enable [7:0], line control [7:0], modem control [1:0], scratch [7:0], rate mode [1:0], tick count [7:0] and sample point [7:0] read back what was written.
- R2: While line control bit 7 is 1, offset 0 reads and writes divisor bits [7:0] and offset 1 reads and writes divisor bits [15:8]. While that bit is 0, offset 1 reaches the interrupt enable register.
- R3: After reset the following hold: line status reads 0x60, TX is high, DTR and RTS are low, the divisor is 1, the rate mode is 0 and the sample point is 0xFF.
- R4: In rate mode 0 or 1 one bit lasts 16 × divisor clocks. A frame is a low start bit, then 8 data bits LSB first, then a high stop bit. TX is high whenever the transmitter is idle.
- R5: In rate mode 2 one bit lasts 4 × divisor clocks.
- R6: In rate mode 3 one bit lasts divisor × (tick count + 1) clocks.
- R7: A divisor of 0 gives the same bit time as a divisor of 1.
- R8: The receiver samples at tick 7 in modes 0 and 1 and at tick 1 in mode 2. In mode 3 it samples at the sample-point tick, or at tick count / 2 when the sample point is larger than the tick count. A completed frame loads the data register and sets line status bit 0. Reading the data register clears bit 0.
- R9: If RX is high at the start bit's sample tick, the frame is dropped and no data is reported.
- R10: A low stop bit sets line status bit 3. A read of line status clears it. The byte is still delivered.
- R11: Line status bit 5 is 1 while the holding register is empty. Bit 6 is 1 only when both the holding register and the shifter are empty.
- R12: A write to offset 2 does three things. Bit 1 clears data ready and aborts a frame being received. Bit 2 discards the held byte and stops the frame in progress, so TX goes high. Bit 0 is stored, and the identification register reads 0xC1 when bit 0 is set and 0x01 when it is clear.
- R13: Modem control bit 0 drives DTR and bit 1 drives RTS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | 4 | Register word offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; reads can clear status |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the addressed register |
| tx_o | output | 1 | Serial output |
| rx_i | input | 1 | Serial input |
| dtr_o | output | 1 | Data terminal ready |
| rts_o | output | 1 | Request to send |

## Verification
The hardest thing to show from the ports is where inside a bit the receiver samples. A clean frame decodes the same way at any tick near mid-bit, so it cannot reveal that tick. The bench therefore drives frames whose data bits invert partway through each bit time. With a one-clock divisor and ten ticks per bit, a sample point early in the bit decodes one byte, and an out-of-range sample point, which falls back to mid-bit, decodes the bitwise inverse. The same cycle-exact driving produces a start pulse too short to survive its sample tick, and a frame whose stop bit is low.

// File: rtl/uart_os.sv
module uart_os #(
  parameter int DIV_W  = 16,
  parameter int TICK_W = 8,
  parameter int AW     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic          tx_o,
  input  logic          rx_i,
  output logic          dtr_o,
  output logic          rts_o
);
  localparam logic [AW-1:0] A_DATA = AW'(0);
  localparam logic [AW-1:0] A_IER  = AW'(1);
  localparam logic [AW-1:0] A_FCR  = AW'(2);
  localparam logic [AW-1:0] A_LCR  = AW'(3);
  localparam logic [AW-1:0] A_MCR  = AW'(4);
  localparam logic [AW-1:0] A_LSR  = AW'(5);
  localparam logic [AW-1:0] A_SPR  = AW'(7);
  localparam logic [AW-1:0] A_MODE = AW'(9);
  localparam logic [AW-1:0] A_SCNT = AW'(10);
  localparam logic [AW-1:0] A_SPT  = AW'(11);
  localparam logic [TICK_W-1:0] LAST16 = TICK_W'(15);
  localparam logic [TICK_W-1:0] LAST4  = TICK_W'(3);
  localparam logic [TICK_W-1:0] MID16  = TICK_W'(7);
  localparam logic [TICK_W-1:0] MID4   = TICK_W'(1);

  logic [7:0]        ier_q, lcr_q, spr_q, thr_q, rbr_q;
  logic [1:0]        mcr_q, mode_q;
  logic [TICK_W-1:0] sc_q, sp_q;
  logic [DIV_W-1:0]  div_q;
  logic              fifo_en_q;
  logic              thr_full, tx_busy, dr_q, fe_q;
  logic              unused_bits;

  assign unused_bits = ^wdata[31:8];

  wire dlab     = lcr_q[7];
  wire wr_thr   = wr_en && addr == A_DATA && !dlab;
  wire rd_rbr   = rd_en && addr == A_DATA && !dlab;
  wire rd_lsr   = rd_en && addr == A_LSR;
  wire tx_flush = wr_en && addr == A_FCR && wdata[2];
  wire rx_flush = wr_en && addr == A_FCR && wdata[1];

  wire [DIV_W-1:0] div_last = (div_q == '0) ? '0 : div_q - DIV_W'(1);

  logic [TICK_W-1:0] tick_last, tick_samp;
  always_comb begin
    case (mode_q)
      2'd2:    begin tick_last = LAST4; tick_samp = MID4; end
      2'd3:    begin
                 tick_last = sc_q;
                 tick_samp = (sp_q > sc_q) ? (sc_q >> 1) : sp_q;
               end
      default: begin tick_last = LAST16; tick_samp = MID16; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ier_q <= '0; lcr_q <= 8'h03; spr_q <= '0; mcr_q <= '0; mode_q <= '0;
      sc_q <= '0; sp_q <= '1; div_q <= DIV_W'(1); fifo_en_q <= 1'b0;
    end else if (wr_en) begin
      case (addr)
        A_DATA: if (dlab) div_q[7:0] <= wdata[7:0];
        A_IER:  if (dlab) div_q[DIV_W-1:8] <= wdata[DIV_W-9:0];
                else ier_q <= wdata[7:0];
        A_FCR:  fifo_en_q <= wdata[0];
        A_LCR:  lcr_q <= wdata[7:0];
        A_MCR:  mcr_q <= wdata[1:0];
        A_SPR:  spr_q <= wdata[7:0];
        A_MODE: mode_q <= wdata[1:0];
        A_SCNT: sc_q <= wdata[TICK_W-1:0];
        A_SPT:  sp_q <= wdata[TICK_W-1:0];
        default: ;
      endcase
    end
  end

  // transmitter
  logic [9:0]        tx_sh;
  logic [3:0]        tx_bit;
  logic [DIV_W-1:0]  tx_pre;
  logic [TICK_W-1:0] tx_tk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_busy <= 1'b0; thr_full <= 1'b0; thr_q <= '0; tx_sh <= '1;
      tx_bit <= '0; tx_pre <= '0; tx_tk <= '0;
    end else if (tx_flush) begin
      tx_busy <= 1'b0; thr_full <= 1'b0;
    end else begin
      if (!tx_busy && thr_full) begin
        tx_busy <= 1'b1; thr_full <= 1'b0;
        tx_sh <= {1'b1, thr_q, 1'b0};
        tx_bit <= '0; tx_pre <= '0; tx_tk <= '0;
      end else if (tx_busy) begin
        if (tx_pre == div_last) begin
          tx_pre <= '0;
          if (tx_tk == tick_last) begin
            tx_tk <= '0;
            if (tx_bit == 4'd9) tx_busy <= 1'b0;
            else begin
              tx_bit <= tx_bit + 4'd1;
              tx_sh <= {1'b1, tx_sh[9:1]};
            end
          end else tx_tk <= tx_tk + TICK_W'(1);
        end else tx_pre <= tx_pre + DIV_W'(1);
      end
      if (wr_thr) begin
        thr_q <= wdata[7:0];
        thr_full <= 1'b1;
      end
    end
  end

  assign tx_o = !tx_busy || tx_sh[0];

  // receiver
  logic              rx_m, rx_s, rx_p, rx_act;
  logic [7:0]        rx_sh;
  logic [3:0]        rx_bit;
  logic [DIV_W-1:0]  rx_pre;
  logic [TICK_W-1:0] rx_tk;

  wire rx_samp = rx_act && rx_pre == div_last && rx_tk == tick_samp;
  wire rx_done = rx_samp && rx_bit == 4'd9;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_m <= 1'b1; rx_s <= 1'b1; rx_p <= 1'b1;
    end else begin
      rx_m <= rx_i; rx_s <= rx_m; rx_p <= rx_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_act <= 1'b0; rx_sh <= '0; rx_bit <= '0; rx_pre <= '0; rx_tk <= '0;
    end else if (rx_flush) begin
      rx_act <= 1'b0;
    end else if (!rx_act) begin
      if (rx_p && !rx_s) begin
        rx_act <= 1'b1; rx_bit <= '0; rx_pre <= '0; rx_tk <= '0;
      end
    end else begin
      if (rx_pre == div_last) begin
        rx_pre <= '0;
        if (rx_tk == tick_last) begin
          rx_tk <= '0;
          rx_bit <= rx_bit + 4'd1;
        end else rx_tk <= rx_tk + TICK_W'(1);
      end else rx_pre <= rx_pre + DIV_W'(1);
      if (rx_samp) begin
        if (rx_bit == 4'd0) begin
          if (rx_s) rx_act <= 1'b0;
        end else if (rx_bit == 4'd9) rx_act <= 1'b0;
        else rx_sh <= {rx_s, rx_sh[7:1]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dr_q <= 1'b0; fe_q <= 1'b0; rbr_q <= '0;
    end else if (rx_flush) begin
      dr_q <= 1'b0;
    end else if (rx_done) begin
      rbr_q <= rx_sh; dr_q <= 1'b1; fe_q <= !rx_s;
    end else begin
      if (rd_rbr) dr_q <= 1'b0;
      if (rd_lsr) fe_q <= 1'b0;
    end
  end

  wire thre = !thr_full;
  wire temt = !thr_full && !tx_busy;

  always_comb begin
    case (addr)
      A_DATA:  rdata = dlab ? 32'(div_q[7:0]) : 32'(rbr_q);
      A_IER:   rdata = dlab ? 32'(div_q[DIV_W-1:8]) : 32'(ier_q);
      A_FCR:   rdata = {24'd0, fifo_en_q, fifo_en_q, 6'b000001};
      A_LCR:   rdata = 32'(lcr_q);
      A_MCR:   rdata = 32'(mcr_q);
      A_LSR:   rdata = {25'd0, temt, thre, 1'b0, fe_q, 2'b00, dr_q};
      A_SPR:   rdata = 32'(spr_q);
      A_MODE:  rdata = 32'(mode_q);
      A_SCNT:  rdata = 32'(sc_q);
      A_SPT:   rdata = 32'(sp_q);
      default: rdata = '0;
    endcase
  end

  assign dtr_o = mcr_q[0];
  assign rts_o = mcr_q[1];
endmodule

// File: rtl/uart_os_chk.sv
module uart_os_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          wr_en,
  input logic          rd_en,
  input logic [2:0]    wlow,
  input logic          dlab,
  input logic          tx_o,
  input logic          tx_busy,
  input logic          thr_full,
  input logic          dr,
  input logic          rx_done,
  input logic          dtr_o
);
  AST_TX_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> tx_o); // R4
  AST_TX_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> !tx_o); // R4
  AST_THR_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(0) && !dlab) |=> (thr_full || tx_busy)); // R11
  AST_RBR_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == AW'(0) && !dlab && !rx_done) |=> !dr); // R8
  AST_RX_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(2) && wlow[1]) |=> !dr); // R12
  AST_TX_FLUSH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(2) && wlow[2]) |=> (tx_o && !thr_full)); // R12
  AST_DTR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(4)) |=> (dtr_o == $past(wlow[0]))); // R13
endmodule

bind uart_os uart_os_chk #(.AW(AW)) i_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .wlow(wdata[2:0]), .dlab(lcr_q[7]), .tx_o(tx_o), .tx_busy(tx_busy),
  .thr_full(thr_full), .dr(dr_q), .rx_done(rx_done), .dtr_o(dtr_o)
);

// File: tb/test_uart_os.sv
module test_uart_os;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;
  // {mode, divisor, tick count, sample point, data, expected clocks per bit}
  localparam logic [63:0] VEC [0:NVEC-1] = '{
    {8'd0, 16'd1, 8'd0,  8'hFF, 8'h35, 16'd16},
    {8'd0, 16'd3, 8'd0,  8'hFF, 8'h5B, 16'd48},
    {8'd2, 16'd2, 8'd0,  8'hFF, 8'hC3, 16'd8},
    {8'd2, 16'd0, 8'd0,  8'hFF, 8'h81, 16'd4},
    {8'd3, 16'd1, 8'd9,  8'd4,  8'hE7, 16'd10},
    {8'd3, 16'd2, 8'd12, 8'd5,  8'h3F, 16'd26},
    {8'd1, 16'd1, 8'd0,  8'hFF, 8'h11, 16'd16}
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0, rdata;
  logic        tx_o, dtr_o, rts_o, rx_i;
  logic        rx_drv = 1'b1, loop = 1'b0;
  int          checks = 0, fails = 0;

  assign rx_i = loop ? tx_o : rx_drv;
  always #(CLK_PERIOD/2) clk = ~clk;

  uart_os i_uart_os (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .tx_o(tx_o), .rx_i(rx_i),
    .dtr_o(dtr_o), .rts_o(rts_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 v = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic cfg(input int mode, input int dv, input int sc, input int sp);
    wr(3, 32'h83); wr(0, dv & 8'hFF); wr(1, (dv >> 8) & 8'hFF); wr(3, 32'h03);
    wr(9, mode); wr(10, sc); wr(11, sp);
  endtask

  task automatic rx_frame(input logic [7:0] d, input int bc, input int split, input logic stopv);
    for (int b = 0; b < 10; b++) begin
      logic val;
      val = (b == 0) ? 1'b0 : (b == 9) ? stopv : d[b-1];
      for (int c = 0; c < bc; c++) begin
        @(negedge clk);
        rx_drv = (split > 0 && b >= 1 && b <= 8 && c >= split) ? ~val : val;
      end
    end
    @(negedge clk); rx_drv = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R3 reset state
    rd(5, v); chk("R3 lsr", v, 32'h60);
    chk("R3 tx idle", {31'd0, tx_o}, 32'd1);
    chk("R3 dtr/rts", {30'd0, rts_o, dtr_o}, 32'd0);
    rd(11, v); chk("R3 sample point", v, 32'hFF);
    rd(9, v); chk("R3 mode", v, 32'd0);
    wr(3, 32'h83); rd(0, v); chk("R3 divisor low", v, 32'd1);
    // R2 divisor latch access
    wr(0, 32'h34); wr(1, 32'h12);
    rd(0, v); chk("R2 div low", v, 32'h34);
    rd(1, v); chk("R2 div high", v, 32'h12);
    wr(3, 32'h03);
    // R1 register map
    wr(1, 32'h0F); rd(1, v); chk("R1 ier", v, 32'h0F);
    wr(7, 32'h5A); rd(7, v); chk("R1 scratch", v, 32'h5A);
    rd(6, v); chk("R1 msr", v, 32'd0);
    rd(3, v); chk("R1 lcr", v, 32'h03);
    wr(10, 32'h21); rd(10, v); chk("R1 tick count", v, 32'h21);
    // R12 identification
    rd(2, v); chk("R12 iir off", v, 32'h01);
    wr(2, 32'h01); rd(2, v); chk("R12 iir on", v, 32'hC1);
    // R13 modem pins
    wr(4, 32'h3); chk("R13 dtr rts", {30'd0, rts_o, dtr_o}, 32'd3);
    wr(4, 32'h2); chk("R13 rts only", {30'd0, rts_o, dtr_o}, 32'd2);

    // table walk with loopback: R4 R5 R6 R7 R8
    loop = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      int bc, cnt, pos;
      logic [7:0] d;
      cfg(VEC[i][63:56], VEC[i][55:40], VEC[i][39:32], VEC[i][31:24]);
      d = VEC[i][23:16];
      bc = VEC[i][15:0];
      wr(0, d);
      cnt = 0;
      while (tx_o && cnt < 100) begin @(negedge clk); cnt++; end
      cnt = 0;
      while (!tx_o && cnt < 1000) begin @(negedge clk); cnt++; end
      chk($sformatf("R4/R5/R6/R7 bit time vec %0d", i), cnt, bc);
      pos = 0;
      for (int b = 0; b < 9; b++) begin
        while (pos < b * bc + bc / 2) begin @(negedge clk); pos++; end
        chk($sformatf("R4 tx bit %0d vec %0d", b, i), {31'd0, tx_o},
            {31'd0, (b == 8) ? 1'b1 : d[b]});
      end
      repeat (bc) @(negedge clk);
      rd(5, v); chk($sformatf("R8 lsr after loopback vec %0d", i), v, 32'h61);
      rd(0, v); chk($sformatf("R8 rbr vec %0d", i), v, {24'd0, d});
      rd(5, v); chk($sformatf("R8 dr cleared vec %0d", i), v & 32'h1, 32'd0);
    end
    loop = 1'b0;

    // R11 holding / shifter flags
    cfg(0, 4, 0, 255);
    wr(0, 32'h55); rd(5, v); chk("R11 thre set temt clear", v, 32'h20);
    wr(0, 32'hAA); rd(5, v); chk("R11 both busy", v, 32'h00);
    repeat (1400) @(negedge clk);
    rd(5, v); chk("R11 all idle", v, 32'h60);
    // R12 transmit flush
    wr(0, 32'h11); wr(0, 32'h22); wr(2, 32'h04);
    chk("R12 tx high after flush", {31'd0, tx_o}, 32'd1);
    rd(5, v); chk("R12 tx flushed lsr", v, 32'h60);
    repeat (200) @(negedge clk);
    chk("R12 tx stays idle", {31'd0, tx_o}, 32'd1);

    // R8 sample point: early tick vs mid-bit fallback
    cfg(3, 1, 9, 1);
    rx_frame(8'hA5, 10, 5, 1'b1);
    rd(0, v); chk("R8 early sample point", v, 32'hA5);
    wr(11, 15);
    rx_frame(8'hA5, 10, 5, 1'b1);
    rd(0, v); chk("R8 out-of-range sample point uses mid", v, 32'h5A);

    // R9 short start pulse
    wr(11, 4);
    for (int c = 0; c < 3; c++) begin @(negedge clk); rx_drv = 1'b0; end
    @(negedge clk); rx_drv = 1'b1;
    repeat (120) @(negedge clk);
    rd(5, v); chk("R9 glitch dropped", v, 32'h60);
    rx_frame(8'h3C, 10, 0, 1'b1);
    rd(0, v); chk("R9 next frame received", v, 32'h3C);

    // R10 framing error
    rx_frame(8'h96, 10, 0, 1'b0);
    repeat (20) @(negedge clk);
    rd(5, v); chk("R10 framing flagged", v, 32'h69);
    rd(5, v); chk("R10 cleared by read", v, 32'h61);
    rd(0, v); chk("R10 data kept", v, 32'h96);

    // R12 receive flush
    rx_frame(8'h77, 10, 0, 1'b1);
    rd(5, v); chk("R12 data ready before flush", v & 32'h1, 32'd1);
    wr(2, 32'h03);
    rd(5, v); chk("R12 rx flushed", v, 32'h60);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule